// File: doc/BRIEF.md
# E1 Receive Clock Recovery Loop

This block recovers a line-rate receive clock from an E1 stream that arrives as two already-sliced digital rails, one for positive marks and one for negative marks. It runs only from a local reference clock at `DIV` times the line rate. A divide-by-`DIV` phase counter produces the recovered clock. Each rising edge of a mark on either rail pulls the counter by at most one reference cycle toward the phase where that edge lines up with the clock's rising edge.

The rails are sampled at the middle of each recovered bit and presented as retimed rail data. A later stage merges them into a single-rail unipolar stream. When no mark edges arrive, nothing is corrected and the clock free-runs at the reference divided by `DIV`. The default `DIV` of 8 gives a free-run rate of one eighth of the reference. The high and low halves of the clock stay within one reference cycle of equal.

Top module: `e1_rx_dpll`

## Requirements
- R1: After a run of mark edges at a steady spacing of `DIV` reference cycles, the loop is locked. In that state, a rail rise that the reference edge T registers makes `rclk_o` rise at that same edge T: `rclk_o` is low in the cycle before T and high in the cycle after T.
- R2: With no mark edges at the inputs, `rclk_o` has a period of exactly `DIV` reference cycles. It is high for `DIV/2` of them and low for the rest.
- R3: Every high run and every low run of `rclk_o` lasts between `DIV/2-1` and `DIV/2+1` reference cycles.
- R4: The phase moves by at most one reference cycle per recovered bit. After the input phase steps, every rise-to-rise interval of `rclk_o` is `DIV-1`, `DIV` or `DIV+1` reference cycles.
- R5: `ret_p_o` and `ret_n_o` change only in the reference cycle after a falling edge of `rclk_o`. When locked, they carry the positive and negative rail levels of the bit that began `DIV/2+1` reference cycles earlier, in bit order, with no bit lost or repeated.
- R6: A zero (both rails low) gives no edge, so the phase counter keeps counting unchanged through any run of zeros. Lock is still held at the next mark.
- R7: `rst` is synchronous and active high. While it is asserted, `rclk_o` is 1 and both retimed outputs are 0. After release, `rclk_o` falls at the `DIV/2`-th reference edge.
- R8: A mark on the negative rail alone steers and locks the loop exactly as a mark on the positive rail does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, `DIV` times the line rate |
| rst | input | 1 | Synchronous active-high reset |
| rail_p_i | input | 1 | Positive-mark rail, high for a positive mark |
| rail_n_i | input | 1 | Negative-mark rail, high for a negative mark |
| rclk_o | output | 1 | Recovered receive clock |
| ret_p_o | output | 1 | Retimed positive rail |
| ret_n_o | output | 1 | Retimed negative rail |

## Verification
A phase correction and a mid-bit retiming sample can fall in the same reference cycle. This happens when a mark edge arrives while the counter sits at the sampling phase. A phase-corrected clock edge and a retimed-output update can also land next to each other. The bench provokes this by stepping the input phase by three reference cycles while marks keep arriving on the negative rail, and it sends scoreboarded data before and after that step. The checks require that each retimed bit still matches the bit driven at that slot. They also require that no rise-to-rise interval leaves `DIV±1` while the loop pulls back into alignment.

// File: rtl/e1_rx_dpll.sv
module e1_rx_dpll #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rail_p_i,
  input  logic rail_n_i,
  output logic rclk_o,
  output logic ret_p_o,
  output logic ret_n_o
);

  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] MID  = CW'(HALF);
  localparam logic [CW-1:0] TOP2 = CW'(DIV - 2);

  logic [CW-1:0] ph, ph_nx;
  logic p_q, n_q, mk_d, fixed;

  wire mark   = p_q | n_q;
  wire edge_s = mark & ~mk_d;
  wire adjust = edge_s & ~fixed & (ph != '0);

  always_comb begin
    ph_nx = (ph == LAST) ? '0 : ph + CW'(1);
    if (adjust) begin
      if (ph < MID)
        ph_nx = ph;
      else if (ph >= TOP2)
        ph_nx = ph - TOP2;
      else
        ph_nx = ph + CW'(2);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      rclk_o  <= 1'b1;
      p_q     <= 1'b0;
      n_q     <= 1'b0;
      mk_d    <= 1'b0;
      fixed   <= 1'b0;
      ret_p_o <= 1'b0;
      ret_n_o <= 1'b0;
    end else begin
      ph     <= ph_nx;
      rclk_o <= (ph_nx < MID);
      p_q    <= rail_p_i;
      n_q    <= rail_n_i;
      mk_d   <= mark;
      if (adjust)
        fixed <= 1'b1;
      else if (ph == MID)
        fixed <= 1'b0;
      if (ph == MID) begin
        ret_p_o <= p_q;
        ret_n_o <= n_q;
      end
    end
  end

endmodule

// File: rtl/e1_rx_dpll_chk.sv
module e1_rx_dpll_chk #(
  parameter int DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic rail_p,
  input logic rail_n,
  input logic rclk,
  input logic ret_p,
  input logic ret_n
);

  localparam int HALF = DIV / 2;

  logic        prev_r, mkp;
  logic [7:0]  run;
  logic [15:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_r <= 1'b1;
      run    <= '0;
      quiet  <= '0;
      mkp    <= 1'b0;
    end else begin
      prev_r <= rclk;
      mkp    <= rail_p | rail_n;
      if (rclk != prev_r)
        run <= 8'd1;
      else if (run != 8'hFF)
        run <= run + 8'd1;
      if ((rail_p | rail_n) && !mkp)
        quiet <= '0;
      else if (quiet != 16'hFFFF)
        quiet <= quiet + 16'd1;
    end
  end

  a_r3_high_run: assert property (@(posedge clk) disable iff (rst)
    (!rclk && prev_r) |-> (int'(run) >= HALF - 1 && int'(run) <= HALF + 1));

  a_r3_low_run: assert property (@(posedge clk) disable iff (rst)
    (rclk && !prev_r) |-> (int'(run) >= HALF - 1 && int'(run) <= HALF + 1));

  a_r2_free_run: assert property (@(posedge clk) disable iff (rst)
    ((rclk != prev_r) && int'(quiet) > 2 * DIV) |-> (int'(run) == HALF));

  a_r5_ret_timing: assert property (@(posedge clk) disable iff (rst)
    (ret_p != $past(ret_p) || ret_n != $past(ret_n)) |-> (!$past(rclk) && $past(rclk, 2)));

endmodule

bind e1_rx_dpll e1_rx_dpll_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst(rst), .rail_p(rail_p_i), .rail_n(rail_n_i),
  .rclk(rclk_o), .ret_p(ret_p_o), .ret_n(ret_n_o)
);

// File: tb/test_e1_rx_dpll.sv
module test_e1_rx_dpll;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rail_p = 1'b0, rail_n = 1'b0;
  logic rclk, ret_p, ret_n;

  int checks = 0, fails = 0;
  int mode = 0;
  string mtag = "";
  bit armed = 0;
  int popped = 0;
  logic [1:0] q[$];

  always #2.5 clk = ~clk;

  e1_rx_dpll #(.DIV(DIV)) i_e1_rx_dpll (
    .clk(clk), .rst(rst), .rail_p_i(rail_p), .rail_n_i(rail_n),
    .rclk_o(rclk), .ret_p_o(ret_p), .ret_n_o(ret_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send_bit(input logic p, input logic n, input bit chk, input string tag);
    logic c0;
    @(negedge clk);
    c0 = rclk;
    rail_p = p;
    rail_n = n;
    if (armed) q.push_back({p, n});
    @(negedge clk);
    if (chk) begin
      check(c0 == 1'b0, {tag, " clock low before mark"}, int'(c0), 0);
      check(rclk == 1'b1, {tag, " clock high after mark"}, int'(rclk), 1);
    end
    repeat (DIV - 2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(rclk == 1'b1, "R7 clock high in reset", int'(rclk), 1);
    check({ret_p, ret_n} == 2'b00, "R7 retimed cleared in reset", int'({ret_p, ret_n}), 0);
    rst = 1'b0;
    rail_p = 1'b0;
    rail_n = 1'b0;
    repeat (HALF - 1) @(negedge clk);
    check(rclk == 1'b1, "R7 clock still high", int'(rclk), 1);
    @(negedge clk);
    check(rclk == 1'b0, "R7 clock falls after DIV/2", int'(rclk), 0);
  endtask

  // monitor: clock shape and scoreboard
  logic prv = 1'b1;
  bit seen = 0, rd_pending = 0;
  int gap = 0, hi = 0;
  always @(negedge clk) begin
    if (rst) begin
      seen = 0; prv = 1'b1; gap = 0; hi = 0; rd_pending = 0;
    end else begin
      if (rd_pending) begin
        rd_pending = 0;
        if (armed && q.size() > 0) begin
          logic [1:0] e;
          e = q.pop_front();
          popped++;
          check({ret_p, ret_n} == e, "R5 retimed rails", int'({ret_p, ret_n}), int'(e));
        end
      end
      if (rclk && !prv) begin
        if (mode == 1 && seen)
          check(gap == DIV, {mtag, " period"}, gap, DIV);
        if (mode == 2 && seen)
          check(gap >= DIV - 1 && gap <= DIV + 1, "R4 step-limited period", gap, DIV);
        seen = (mode != 0);
        gap = 1;
        hi = 1;
      end else begin
        gap++;
        if (rclk) hi++;
      end
      if (!rclk && prv) begin
        if (mode == 1 && seen)
          check(hi == HALF, {mtag, " high time"}, hi, HALF);
        rd_pending = 1;
      end
      prv = rclk;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();

    // R2 free run
    mtag = "R2"; mode = 1;
    repeat (10 * DIV) @(negedge clk);
    mode = 0;

    // R1 lock from arbitrary phase
    repeat (3) @(negedge clk);
    for (int i = 0; i < 24; i++) send_bit(i % 2 == 0, 1'b0, 1'b0, "");
    send_bit(1'b1, 1'b0, 1'b1, "R1");
    send_bit(1'b0, 1'b0, 1'b0, "");

    // R5 scoreboard, mixed marks
    armed = 1;
    popped = 0;
    for (int i = 0; i < 40; i++) begin
      logic p, n;
      p = (i % 3 == 0) || (i % 7 == 6);
      n = (i % 3 == 1) && (i % 7 != 6);
      send_bit(p, n, 1'b0, "");
    end
    armed = 0;
    check(q.size() == 0, "R5 all bits retimed", q.size(), 0);
    check(popped == 40, "R5 retimed count", popped, 40);

    // R6 zero run holds phase
    mtag = "R6"; mode = 1;
    for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b0, 1'b0, "");
    mode = 0;
    send_bit(1'b1, 1'b0, 1'b1, "R6");
    send_bit(1'b0, 1'b0, 1'b0, "");

    // R4/R8 phase step, negative rail only
    repeat (3) @(negedge clk);
    mode = 2;
    for (int i = 0; i < 14; i++) send_bit(1'b0, i % 2 == 0, 1'b0, "");
    mode = 0;
    send_bit(1'b0, 1'b1, 1'b1, "R8");
    send_bit(1'b0, 1'b0, 1'b0, "");

    // R5 after the step
    armed = 1;
    popped = 0;
    for (int i = 0; i < 24; i++) send_bit(i % 4 == 1, i % 4 == 3 || i % 5 == 0, 1'b0, "");
    armed = 0;
    check(popped == 24, "R5 retimed count after step", popped, 24);

    // R7 reset mid-run with a mark present
    rail_p = 1'b1;
    do_reset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule